// File: doc/BRIEF.md
# Dual-Line Level-Sensitive Interrupt Controller

This block gathers twenty-three level-sensitive interrupt requests from the peripherals and external pins of a chip. It drives two processor interrupt lines from them: a fast line for urgent events and a normal line for everything else. The line a source feeds is fixed by its bit position. Bits 0 to 3 of the first register set feed the fast line. Bits 4 to 15 of the first set, and all seven implemented bits of the second set, feed the normal line. Software services the fast line before the normal one. Within a line there is no hardware ordering: every enabled active source is simply ORed onto the line.

Each register set has two registers on a small synchronous register bus with address, write strobe, write data and combinational read data. The enable register can be read and written, and a 1 bit lets its source through. The level register is read-only and shows the raw, unmasked level of each source after a two-flop synchronizer. Nothing is latched inside the block. A request stays visible until its device drops it, and the line falls again on its own once that happens. The two lines are registered, so they follow the level register by one clock.

Top module: `intc_dual_line`

## Requirements
- R1: After reset both enable registers read 0, and both `fiq_o` and `irq_o` are low. While every enable bit is 0, neither line asserts.
- R2: Address 0 is the 16-bit enable register of set A, which can be read and written. Address 2 is the enable register of set B: only bits 6:0 are stored, and bits 15:7 always read 0.
- R3: Address 1 reads the synchronized levels of sources 0–15 in bits 15:0. Address 3 reads sources 16–22 in bits 6:0, with bits 15:7 reading 0. A source change driven between clock edges is visible in the level register after exactly two rising edges.
- R4: A write to address 1 or 3 changes no register. Both level registers still read the source levels, and both enable registers keep their values.
- R5: `fiq_o` equals the OR of (level AND enable) over set A bits 3:0. It is registered, so it changes one rising edge after the level register does.
- R6: `irq_o` equals the OR of (level AND enable) over set A bits 15:4 and set B bits 6:0, with the same one-edge registration.
- R7: Requests are not latched. Once every enabled source drops, the lines fall again without any access from software.
- R8: A source whose enable bit is 0 still shows in the level register, but it does not assert either line.
- R9: Sources 0–3 never affect `irq_o`, and sources 4–22 never affect `fiq_o`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside the block |
| src_req | input | 23 | Level-sensitive request inputs, which may be asynchronous |
| reg_addr | input | 2 | Register address: 0 enable A, 1 level A, 2 enable B, 3 level B |
| reg_we | input | 1 | Write strobe, sampled on the rising edge |
| reg_wdata | input | 16 | Write data |
| reg_rdata | output | 16 | Read data for `reg_addr`, combinational |
| fiq_o | output | 1 | Fast interrupt line, active high |
| irq_o | output | 1 | Normal interrupt line, active high |

## Verification
On every cycle, the assertions check the following:
- the two-edge delay from a source pin to the level register;
- that both lines stay quiet while all enables are 0, and fall once no enabled source is active;
- that the fast line only answers sources 0–3;
- that writes to the level addresses leave the enable registers untouched;
- that the unimplemented bits of set B read 0.

Only the bench scenarios can show the exact line value for a given mix of levels and enables, the one-edge lag of the lines behind the level register, and the read-back of written enables. The bench covers these with directed cases and with seeded random combinations of sources and enables.

// File: rtl/intc_pkg.sv
package intc_pkg;
  parameter int NUM_SRC   = 23;
  parameter int NUM_FAST  = 4;
  parameter int BANK_W    = 16;
  parameter int SYNC_LEN  = 2;
  localparam int NUM_HIGH = NUM_SRC - BANK_W;

  typedef enum logic [1:0] {
    ADR_EN_A  = 2'd0,
    ADR_LVL_A = 2'd1,
    ADR_EN_B  = 2'd2,
    ADR_LVL_B = 2'd3
  } reg_adr_e;
endpackage

// File: rtl/intc_sync.sv
module intc_sync #(
  parameter int W      = 23,
  parameter int STAGES = 2
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] d_async,
  output logic [W-1:0] q_sync
);
  logic [STAGES-1:0][W-1:0] stg_q;
  logic [STAGES-1:0][W-1:0] stg_d;

  always_comb begin
    stg_d[0] = d_async;
    for (int s = 1; s < STAGES; s++) stg_d[s] = stg_q[s-1];
  end

  genvar g;
  generate
    for (g = 0; g < STAGES; g++) begin : g_stage
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) stg_q[g] <= '0;
        else        stg_q[g] <= stg_d[g];
      end
    end
  endgenerate

  assign q_sync = stg_q[STAGES-1];
endmodule

// File: rtl/intc_regs.sv
module intc_regs
  import intc_pkg::*;
#(
  parameter int N_SRC  = NUM_SRC,
  parameter int SET_W  = BANK_W
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [1:0]       addr,
  input  logic             we,
  input  logic [SET_W-1:0] wdata,
  input  logic [N_SRC-1:0] level,
  output logic [N_SRC-1:0] enable,
  output logic [SET_W-1:0] rdata
);
  localparam int NB = N_SRC - SET_W;

  logic [SET_W-1:0] en_a_q, en_a_d;
  logic [NB-1:0]    en_b_q, en_b_d;

  always_comb begin
    en_a_d = en_a_q;
    en_b_d = en_b_q;
    if (we) begin
      case (reg_adr_e'(addr))
        ADR_EN_A: en_a_d = wdata;
        ADR_EN_B: en_b_d = wdata[NB-1:0];
        default:  ;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      en_a_q <= '0;
      en_b_q <= '0;
    end else begin
      en_a_q <= en_a_d;
      en_b_q <= en_b_d;
    end
  end

  always_comb begin
    case (reg_adr_e'(addr))
      ADR_EN_A:  rdata = en_a_q;
      ADR_LVL_A: rdata = level[SET_W-1:0];
      ADR_EN_B:  rdata = SET_W'(en_b_q);
      default:   rdata = SET_W'(level[N_SRC-1:SET_W]);
    endcase
  end

  assign enable = {en_b_q, en_a_q};

  AST_LEVEL_WR_IGNORED: assert property (@(posedge clk) disable iff (!rst_n)
    (we && addr[0]) |=> $stable(enable)); // R4
  AST_EN_A_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
    (we && addr == ADR_EN_A) |=> (enable[SET_W-1:0] == $past(wdata))); // R2
  AST_B_UPPER_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
    addr[1] |-> (rdata[SET_W-1:NB] == '0)); // R2
endmodule

// File: rtl/intc_lines.sv
module intc_lines #(
  parameter int N_SRC  = 23,
  parameter int N_FAST = 4
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [N_SRC-1:0] level,
  input  logic [N_SRC-1:0] enable,
  output logic             fiq,
  output logic             irq
);
  logic [N_SRC-1:0] active;
  logic             fiq_d, irq_d;

  always_comb begin
    active = level & enable;
    fiq_d  = |active[N_FAST-1:0];
    irq_d  = |active[N_SRC-1:N_FAST];
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      fiq <= 1'b0;
      irq <= 1'b0;
    end else begin
      fiq <= fiq_d;
      irq <= irq_d;
    end
  end

  AST_FAST_ONLY_LOW_BITS: assert property (@(posedge clk) disable iff (!rst_n)
    ((level[N_FAST-1:0] & enable[N_FAST-1:0]) == '0) |=> !fiq); // R9
  AST_LINES_DROP: assert property (@(posedge clk) disable iff (!rst_n)
    ((level & enable) == '0) |=> (!fiq && !irq)); // R7
endmodule

// File: rtl/intc_dual_line.sv
module intc_dual_line
  import intc_pkg::*;
#(
  parameter int N_SRC  = NUM_SRC,
  parameter int N_FAST = NUM_FAST,
  parameter int SET_W  = BANK_W,
  parameter int SYNC_N = SYNC_LEN
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [N_SRC-1:0] src_req,
  input  logic [1:0]       reg_addr,
  input  logic             reg_we,
  input  logic [SET_W-1:0] reg_wdata,
  output logic [SET_W-1:0] reg_rdata,
  output logic             fiq_o,
  output logic             irq_o
);
  logic [1:0]       rst_pipe;
  logic             rst_int_n;
  logic [N_SRC-1:0] level;
  logic [N_SRC-1:0] enable;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_pipe <= 2'b00;
    else        rst_pipe <= {rst_pipe[0], 1'b1};
  end
  assign rst_int_n = rst_pipe[1];

  intc_sync #(.W(N_SRC), .STAGES(SYNC_N)) i_sync (
    .clk(clk), .rst_n(rst_int_n), .d_async(src_req), .q_sync(level));

  intc_regs #(.N_SRC(N_SRC), .SET_W(SET_W)) i_regs (
    .clk(clk), .rst_n(rst_int_n), .addr(reg_addr), .we(reg_we),
    .wdata(reg_wdata), .level(level), .enable(enable), .rdata(reg_rdata));

  intc_lines #(.N_SRC(N_SRC), .N_FAST(N_FAST)) i_lines (
    .clk(clk), .rst_n(rst_int_n), .level(level), .enable(enable),
    .fiq(fiq_o), .irq(irq_o));

  logic [1:0] warm_q;
  always_ff @(posedge clk or negedge rst_int_n) begin
    if (!rst_int_n)          warm_q <= 2'd0;
    else if (warm_q != 2'd3) warm_q <= warm_q + 2'd1;
  end

  AST_SYNC_DELAY: assert property (@(posedge clk) disable iff (!rst_int_n)
    (warm_q == 2'd3) |-> (level == $past(src_req, 2))); // R3
  AST_QUIET_ALL_DISABLED: assert property (@(posedge clk) disable iff (!rst_int_n)
    (enable == '0) |=> (!fiq_o && !irq_o)); // R1
endmodule

// File: tb/test_intc_dual_line.sv
module test_intc_dual_line;
  logic        clk = 1'b0;
  logic        rst_n;
  logic [22:0] src_req;
  logic [1:0]  reg_addr;
  logic        reg_we;
  logic [15:0] reg_wdata;
  logic [15:0] reg_rdata;
  logic        fiq_o, irq_o;

  int n_chk = 0;
  int n_fail = 0;
  bit done = 0;

  logic [15:0] m_a;
  logic [6:0]  m_b;

  always #5 clk = ~clk;

  intc_dual_line i_intc_dual_line (
    .clk(clk), .rst_n(rst_n), .src_req(src_req), .reg_addr(reg_addr),
    .reg_we(reg_we), .reg_wdata(reg_wdata), .reg_rdata(reg_rdata),
    .fiq_o(fiq_o), .irq_o(irq_o));

  function automatic logic exp_fiq(logic [22:0] s, logic [15:0] a);
    return |(s[3:0] & a[3:0]);
  endfunction

  function automatic logic exp_irq(logic [22:0] s, logic [15:0] a, logic [6:0] b);
    return (|(s[15:4] & a[15:4])) | (|(s[22:16] & b));
  endfunction

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [1:0] a, input logic [15:0] d);
    @(negedge clk);
    reg_addr = a; reg_wdata = d; reg_we = 1'b1;
    @(negedge clk);
    reg_we = 1'b0;
  endtask

  task automatic rd(input logic [1:0] a, output logic [15:0] d);
    reg_addr = a;
    #1;
    d = reg_rdata;
  endtask

  task automatic settle();
    repeat (3) @(negedge clk);
  endtask

  task automatic set_masks(input logic [15:0] a, input logic [6:0] b);
    wr(2'd0, a); wr(2'd2, {9'h0, b});
    m_a = a; m_b = b;
  endtask

  task automatic full_check(input string req);
    logic [15:0] v;
    rd(2'd1, v); chk({req, " level A"}, v, src_req[15:0]);
    rd(2'd3, v); chk({req, " level B"}, v, {9'h0, src_req[22:16]});
    chk({req, " fiq"}, fiq_o, exp_fiq(src_req, m_a));
    chk({req, " irq"}, irq_o, exp_irq(src_req, m_a, m_b));
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      n_fail++;
      $display("FAIL watchdog actual=timeout expected=completion");
      $display("TB_RESULT checks=%0d failures=%0d", n_chk, n_fail);
      $finish;
    end
  end

  initial begin
    logic [15:0] v;
    void'($urandom(32'h5eed_1234));
    rst_n = 1'b0; src_req = '0; reg_addr = '0; reg_we = 1'b0; reg_wdata = '0;
    m_a = '0; m_b = '0;
    repeat (4) @(negedge clk);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);

    // R1: reset state
    rd(2'd0, v); chk("R1 enable A reset", v, 16'h0);
    rd(2'd2, v); chk("R1 enable B reset", v, 16'h0);
    chk("R1 fiq reset", fiq_o, 1'b0);
    chk("R1 irq reset", irq_o, 1'b0);

    // R8 / R1: all sources active, nothing enabled
    src_req = '1; settle();
    rd(2'd1, v); chk("R8 level A visible", v, 16'hffff);
    rd(2'd3, v); chk("R3 level B upper zero", v, 16'h007f);
    chk("R8 fiq blocked", fiq_o, 1'b0);
    chk("R8 irq blocked", irq_o, 1'b0);

    // R2: enable read/write
    set_masks(16'ha5c3, 7'h7f);
    rd(2'd0, v); chk("R2 enable A readback", v, 16'ha5c3);
    wr(2'd2, 16'hffff);
    rd(2'd2, v); chk("R2 enable B upper zero", v, 16'h007f);

    // R3 / R5: latency, source 0 only
    src_req = '0; set_masks(16'h0001, 7'h0); settle();
    @(negedge clk); src_req = 23'h1;
    @(negedge clk);
    rd(2'd1, v); chk("R3 not yet after one edge", v, 16'h0);
    @(negedge clk);
    rd(2'd1, v); chk("R3 visible after two edges", v, 16'h1);
    chk("R5 fiq lags level", fiq_o, 1'b0);
    @(negedge clk);
    chk("R5 fiq asserted", fiq_o, 1'b1);
    chk("R9 irq ignores fast", irq_o, 1'b0);

    // R7: level drop clears line
    src_req = '0; settle();
    chk("R7 fiq falls", fiq_o, 1'b0);

    // R9: fast group only, all enabled
    set_masks(16'hffff, 7'h7f);
    src_req = 23'h00000f; settle();
    chk("R9 fast srcs fiq", fiq_o, 1'b1);
    chk("R9 fast srcs no irq", irq_o, 1'b0);
    src_req = 23'h7ffff0; settle();
    chk("R9 normal srcs no fiq", fiq_o, 1'b0);
    chk("R9 normal srcs irq", irq_o, 1'b1);

    // R6: set B top source only
    set_masks(16'h0000, 7'h40);
    src_req = 23'h400000; settle();
    chk("R6 set B source irq", irq_o, 1'b1);
    src_req = '0; settle();
    chk("R7 irq falls", irq_o, 1'b0);

    // R4: writes to level registers ignored
    set_masks(16'h00f0, 7'h05);
    src_req = 23'h2a_0f0f; settle();
    wr(2'd1, 16'h1234);
    wr(2'd3, 16'hffff);
    rd(2'd1, v); chk("R4 level A unchanged", v, 16'h0f0f);
    rd(2'd3, v); chk("R4 level B unchanged", v, 16'h002a);
    rd(2'd0, v); chk("R4 enable A kept", v, 16'h00f0);
    rd(2'd2, v); chk("R4 enable B kept", v, 16'h0005);

    // R5 / R6 / R3: random mix
    for (int i = 0; i < 250; i++) begin
      if (i % 4 == 0) set_masks(16'($urandom), 7'($urandom));
      if (i % 3 == 0) src_req = 23'($urandom) & 23'($urandom);
      else            src_req = 23'($urandom);
      settle();
      full_check("R5/R6 random");
    end

    done = 1;
    $display("TB_RESULT checks=%0d failures=%0d", n_chk, n_fail);
    $finish;
  end
endmodule